// File: doc/BRIEF.md
# Predicated Element Compacting Issue Unit

This unit executes one masked vector add over a fixed set of element positions. An element takes part only when its predicate bit is set and its position lies below the requested vector length. Before issue, the unit packs the active elements together: each cycle it takes the lowest-indexed pending elements and routes them onto consecutive ALU lanes. A masked-off element never occupies a lane. The run time therefore depends on how many elements are active, not on the vector length.

Each lane adds its two operands. The sum is written back to the element slot it came from, and a per-slot write-enable pulse marks the slots updated in that cycle. Slots that are not written keep whatever they last held; they are never cleared. A single-cycle done pulse marks the cycle in which the final group is written back. A start request that arrives while an operation is running is dropped.

Top module: `spc_issue_unit`

## Requirements
- R1: Element i (operand and result bits [i*DATA_W +: DATA_W], predicate bit i) is enabled only when mask_i[i] is 1 and i < vlen_i. A vlen_i of NUM_ELEM or more limits nothing. A disabled element is never written.
- R2: Each cycle the unit issues at most LANES enabled elements. It always takes the lowest-indexed ones still pending, so every group except the last is full, and elements issue in ascending index order.
- R3: The group issued in the c-th cycle after the clock edge that accepts start appears as one-cycle wr_en_o pulses after edge c. At the same time, each written slot holds (a + b) mod 2^DATA_W for that element.
- R4: A slot whose wr_en_o bit is low keeps its previous value, including across operations. Disabled elements are never zeroed.
- R5: done_o is high for exactly one cycle, after edge k, where k = ceil(n / LANES) and n is the number of enabled elements. This is the same cycle as the last group's write enables.
- R6: With no enabled element, done_o pulses after the first edge following acceptance, and no wr_en_o bit is raised.
- R7: start_i is ignored from the accepting edge up to and including the edge that raises done_o. Operands, mask and length captured at acceptance are the only ones used.
- R8: After reset, wr_en_o, wr_data_o and done_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation when idle |
| mask_i | input | NUM_ELEM | Predicate bit per element |
| vlen_i | input | $clog2(NUM_ELEM+1) | Vector length |
| op_a_i | input | NUM_ELEM*DATA_W | First operand per element |
| op_b_i | input | NUM_ELEM*DATA_W | Second operand per element |
| wr_en_o | output | NUM_ELEM | Per-slot write strobe |
| wr_data_o | output | NUM_ELEM*DATA_W | Per-slot result, held between writes |
| done_o | output | 1 | Operation complete pulse |

## Verification
The bench builds two instances with NUM_ELEM=8 and DATA_W=16 and drives both from the same stimulus. One instance has LANES=4 and the other has LANES=1.

The four-lane instance tests compaction: a partly filled final group, and six active elements that split four then two. The single-lane instance tests that the cycle count equals the number of active elements and that elements issue in strict ascending order.

Because the two instances finish at different times, a restart pulse can be placed so that both are still busy when it arrives.

// File: rtl/spc_pkg.sv
package spc_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } spc_state_e;
endpackage

// File: rtl/spc_pred_gen.sv
module spc_pred_gen #(
  parameter int NUM_ELEM = 8,
  localparam int VL_W = $clog2(NUM_ELEM + 1)
) (
  input  logic [NUM_ELEM-1:0] mask_i,
  input  logic [VL_W-1:0]     vlen_i,
  output logic [NUM_ELEM-1:0] en_o
);
  for (genvar i = 0; i < NUM_ELEM; i++) begin : g_el
    assign en_o[i] = mask_i[i] && (int'(vlen_i) > i);
  end
endmodule

// File: rtl/spc_lane_pick.sv
// Rank-based compaction: the r-th pending element goes to lane r.
module spc_lane_pick #(
  parameter int NUM_ELEM = 8,
  parameter int LANES    = 4
) (
  input  logic [NUM_ELEM-1:0]            pend_i,
  output logic [LANES-1:0][NUM_ELEM-1:0] grant_o,
  output logic [NUM_ELEM-1:0]            issue_o
);
  localparam int RANK_W = $clog2(NUM_ELEM + 1);

  logic [RANK_W-1:0] rank;

  always_comb begin
    grant_o = '0;
    rank    = '0;
    for (int i = 0; i < NUM_ELEM; i++) begin
      if (pend_i[i]) begin
        for (int l = 0; l < LANES; l++) begin
          if (rank == RANK_W'(l)) grant_o[l][i] = 1'b1;
        end
        rank = rank + RANK_W'(1);
      end
    end
  end

  always_comb begin
    issue_o = '0;
    for (int l = 0; l < LANES; l++) issue_o = issue_o | grant_o[l];
  end
endmodule

// File: rtl/spc_lane_alu.sv
module spc_lane_alu #(
  parameter int NUM_ELEM = 8,
  parameter int DATA_W   = 16
) (
  input  logic [NUM_ELEM-1:0]             sel_i,
  input  logic [NUM_ELEM-1:0][DATA_W-1:0] a_i,
  input  logic [NUM_ELEM-1:0][DATA_W-1:0] b_i,
  output logic                            vld_o,
  output logic [DATA_W-1:0]               sum_o
);
  logic [DATA_W-1:0] op_a, op_b;

  // one-hot and-or operand mux
  always_comb begin
    op_a = '0;
    op_b = '0;
    for (int i = 0; i < NUM_ELEM; i++) begin
      if (sel_i[i]) begin
        op_a = op_a | a_i[i];
        op_b = op_b | b_i[i];
      end
    end
  end

  assign sum_o = op_a + op_b;
  assign vld_o = |sel_i;
endmodule

// File: rtl/spc_issue_unit.sv
module spc_issue_unit
  import spc_pkg::*;
#(
  parameter int NUM_ELEM = 8,
  parameter int DATA_W   = 16,
  parameter int LANES    = 4,
  localparam int VL_W    = $clog2(NUM_ELEM + 1)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         start_i,
  input  logic [NUM_ELEM-1:0]          mask_i,
  input  logic [VL_W-1:0]              vlen_i,
  input  logic [NUM_ELEM*DATA_W-1:0]   op_a_i,
  input  logic [NUM_ELEM*DATA_W-1:0]   op_b_i,
  output logic [NUM_ELEM-1:0]          wr_en_o,
  output logic [NUM_ELEM*DATA_W-1:0]   wr_data_o,
  output logic                         done_o
);
  typedef logic [NUM_ELEM-1:0][DATA_W-1:0] elem_vec_t;

  spc_state_e state_q;
  logic [NUM_ELEM-1:0] pend_q;
  elem_vec_t a_q, b_q, data_q;
  logic [NUM_ELEM-1:0] wr_en_q;
  logic done_q;

  logic [NUM_ELEM-1:0] en;
  logic [LANES-1:0][NUM_ELEM-1:0] grant;
  logic [NUM_ELEM-1:0] issue;
  logic [LANES-1:0] lane_vld;
  logic [LANES-1:0][DATA_W-1:0] lane_sum;
  elem_vec_t wb_data;
  logic [NUM_ELEM-1:0] pend_nxt;

  spc_pred_gen #(.NUM_ELEM(NUM_ELEM)) u_pred (
    .mask_i (mask_i),
    .vlen_i (vlen_i),
    .en_o   (en)
  );

  spc_lane_pick #(.NUM_ELEM(NUM_ELEM), .LANES(LANES)) u_pick (
    .pend_i  (pend_q),
    .grant_o (grant),
    .issue_o (issue)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    spc_lane_alu #(.NUM_ELEM(NUM_ELEM), .DATA_W(DATA_W)) u_alu (
      .sel_i (grant[l]),
      .a_i   (a_q),
      .b_i   (b_q),
      .vld_o (lane_vld[l]),
      .sum_o (lane_sum[l])
    );
  end

  // scatter lane results back to their home slots
  always_comb begin
    wb_data = data_q;
    for (int i = 0; i < NUM_ELEM; i++) begin
      for (int l = 0; l < LANES; l++) begin
        if (grant[l][i] && lane_vld[l]) wb_data[i] = lane_sum[l];
      end
    end
  end

  assign pend_nxt = pend_q & ~issue;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pend_q  <= '0;
      a_q     <= '0;
      b_q     <= '0;
      data_q  <= '0;
      wr_en_q <= '0;
      done_q  <= 1'b0;
    end else begin
      wr_en_q <= '0;
      done_q  <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q <= ST_RUN;
            pend_q  <= en;
            a_q     <= op_a_i;
            b_q     <= op_b_i;
          end
        end
        ST_RUN: begin
          pend_q  <= pend_nxt;
          wr_en_q <= issue;
          data_q  <= wb_data;
          if (pend_nxt == '0) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign wr_en_o   = wr_en_q;
  assign wr_data_o = data_q;
  assign done_o    = done_q;
endmodule

// File: rtl/spc_issue_chk.sv
module spc_issue_chk #(
  parameter int NUM_ELEM = 8,
  parameter int DATA_W   = 16,
  parameter int LANES    = 4
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       busy_i,
  input logic [NUM_ELEM-1:0]        pend_i,
  input logic [NUM_ELEM-1:0]        wr_en_o,
  input logic [NUM_ELEM*DATA_W-1:0] wr_data_o,
  input logic                       done_o
);
  // R2
  lane_limit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(wr_en_o) <= LANES);

  // R3
  write_from_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|wr_en_o) |-> $past(busy_i));

  // R5
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R6
  empty_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && pend_i == '0) |=> (done_o && wr_en_o == '0));

  // R7
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_i);

  for (genvar i = 0; i < NUM_ELEM; i++) begin : g_hold
    // R4
    slot_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wr_en_o[i] |-> $stable(wr_data_o[i*DATA_W +: DATA_W]));
  end
endmodule

bind spc_issue_unit spc_issue_chk #(
  .NUM_ELEM (NUM_ELEM),
  .DATA_W   (DATA_W),
  .LANES    (LANES)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .busy_i    (state_q == spc_pkg::ST_RUN),
  .pend_i    (pend_q),
  .wr_en_o   (wr_en_o),
  .wr_data_o (wr_data_o),
  .done_o    (done_o)
);

// File: tb/spc_issue_unit_tb_top.sv
module spc_issue_unit_tb_top;
  localparam int NE = 8;
  localparam int DW = 16;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic [NE-1:0] mask_i = '0;
  logic [3:0] vlen_i = '0;
  logic [NE*DW-1:0] op_a_i = '0, op_b_i = '0;

  logic [NE-1:0] we [2];
  logic [NE*DW-1:0] wd [2];
  logic dn [2];

  int n_chk = 0;
  int n_fail = 0;
  logic [DW-1:0] exp_data [2][NE];

  always #5 clk_i = ~clk_i;

  spc_issue_unit #(.NUM_ELEM(NE), .DATA_W(DW), .LANES(4)) dut_i (
    .clk_i, .rst_ni, .start_i, .mask_i, .vlen_i, .op_a_i, .op_b_i,
    .wr_en_o(we[0]), .wr_data_o(wd[0]), .done_o(dn[0])
  );

  spc_issue_unit #(.NUM_ELEM(NE), .DATA_W(DW), .LANES(1)) dut_l1_i (
    .clk_i, .rst_ni, .start_i, .mask_i, .vlen_i, .op_a_i, .op_b_i,
    .wr_en_o(we[1]), .wr_data_o(wd[1]), .done_o(dn[1])
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  // Runs one operation on both instances and checks every cycle.
  task automatic run_op(input string name, input logic [NE-1:0] m,
                        input logic [3:0] vl, input bit restart);
    logic [DW-1:0] a [NE];
    logic [DW-1:0] b [NE];
    logic [NE-1:0] en;
    int n;
    en = '0;
    for (int i = 0; i < NE; i++) begin
      a[i] = DW'($urandom);
      b[i] = DW'($urandom);
      op_a_i[i*DW +: DW] = a[i];
      op_b_i[i*DW +: DW] = b[i];
      if (m[i] && i < int'(vl)) en[i] = 1'b1; // R1
    end
    n = $countones(en);
    mask_i = m;
    vlen_i = vl;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    for (int c = 1; c <= 12; c++) begin
      @(negedge clk_i);
      for (int d = 0; d < 2; d++) begin
        int lanes = (d == 0) ? 4 : 1;
        int k = (n == 0) ? 1 : (n + lanes - 1) / lanes;
        int r = 0;
        logic [NE-1:0] exp_we = '0;
        logic [NE*DW-1:0] exp_bus;
        for (int i = 0; i < NE; i++) begin
          if (en[i]) begin
            if (r >= (c - 1) * lanes && r < c * lanes) exp_we[i] = 1'b1;
            r++;
          end
        end
        for (int i = 0; i < NE; i++) begin
          if (exp_we[i]) exp_data[d][i] = a[i] + b[i];
          exp_bus[i*DW +: DW] = exp_data[d][i];
        end
        chk(we[d] == exp_we, restart ? "R7" : "R1_R2",
            $sformatf("%s d%0d c%0d wr_en", name, d, c), 128'(we[d]), 128'(exp_we));
        chk(dn[d] == (c == k), (n == 0) ? "R6" : "R5",
            $sformatf("%s d%0d c%0d done", name, d, c), 128'(dn[d]), 128'(c == k));
        chk(wd[d] == exp_bus, "R3_R4",
            $sformatf("%s d%0d c%0d data", name, d, c), wd[d], exp_bus);
      end
      if (restart && c == 1) begin
        op_a_i = {4{32'hDEAD_BEEF}};
        op_b_i = {4{32'h1234_5678}};
        mask_i = '1;
        vlen_i = 4'd8;
        start_i = 1'b1;
      end
      if (restart && c == 2) start_i = 1'b0;
    end
  endtask

  task automatic reset_test();
    for (int d = 0; d < 2; d++) begin
      for (int i = 0; i < NE; i++) exp_data[d][i] = '0;
      // R8
      chk(we[d] == '0 && dn[d] == 1'b0 && wd[d] == '0, "R8",
          $sformatf("reset d%0d", d), {we[d], 7'd0, dn[d], 112'd0}, 128'd0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    reset_test();
    rst_ni = 1'b1;
    @(negedge clk_i);
    run_op("six_on", 8'b1011_0111, 4'd8, 1'b0);
    run_op("all_on", 8'hFF, 4'd8, 1'b0);
    run_op("sparse_keep", 8'h55, 4'd8, 1'b0);      // R4 slots 1,3,5,7 hold
    run_op("none_on", 8'h00, 4'd8, 1'b0);          // R6
    run_op("vl_zero", 8'hFF, 4'd0, 1'b0);          // R1 + R6
    run_op("vl_trunc", 8'hFF, 4'd3, 1'b0);         // R1
    run_op("vl_over", 8'b1010_0011, 4'd15, 1'b0);  // R1
    run_op("top_only", 8'h80, 4'd8, 1'b0);
    run_op("five_odd", 8'b1111_1000, 4'd8, 1'b0);  // R2 partial last group
    run_op("restart", 8'hFF, 4'd8, 1'b1);          // R7
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end
endmodule